// File: doc/BRIEF.md
# PDM Microphone Decimator with Staggered Ones-Count Windows

This block generates the bit clock for a pulse-density-modulated microphone and reads the microphone's one-bit output on the edge that a select level chooses. It converts the resulting bit stream into 7-bit PCM samples by counting ones. The system clock is divided by an even parameter `CLK_DIV` to produce the microphone clock, with 50% duty. Elaboration stops with an error when the resulting rate falls outside 1 MHz to 3.3 MHz. The default is 100 MHz / 42, about 2.38 MHz. The edge-select input is captured while reset is held, and that value is driven to the microphone. A low level selects the rising edge and a high level selects the falling edge.

Each captured bit passes through a two-flop synchronizer. It is then counted by two ones-counters, each over a window of 128 consecutive bits. The second counter's windows start 64 bits after the first counter's windows. Each counter restarts from zero at the start of every window. Each counter on its own yields one sample per 128 bits. Because the two are staggered, the output carries one sample every 64 bits, and the samples come from the two counters in turn.

The output is a plain strobe stream with no back-pressure. `pcm_valid` is high for exactly one system cycle per sample, and the consumer must take the sample in that cycle. `pcm_data` and `pcm_src` hold their values until the next strobe, so a late reader still sees the latest sample.

Top module: `pdm_decimator`

## Requirements
- R1: `mic_clk` is low in reset. After reset it toggles every `CLK_DIV/2` system cycles, so one full period lasts `CLK_DIV` system cycles.
- R3: `mic_sel` drives the value `edge_sel` had while reset was asserted. When `mic_sel` is 0, data is taken at the rising edge of `mic_clk`. When it is 1, data is taken at the falling edge. Data present at the opposite edge has no effect.
- R4: A change of `edge_sel` after reset is released changes neither `mic_sel` nor the sampling edge nor any sample value.
- R5: Counter 0 (`pcm_src` = 0) reports the number of ones among captured bits 128k to 128k+127, for k = 0, 1, 2, ..., where bit 0 is the first bit captured after reset.
- R6: Counter 1 (`pcm_src` = 1) reports the number of ones among captured bits 128k+64 to 128k+191. It produces no result before bit 191 has been captured.
- R7: A window in which all 128 bits are one reports 127. Every other window reports its exact count.
- R8: `pcm_valid` is a single-cycle pulse. The first sample after reset has `pcm_src` = 0, and later samples alternate between 1 and 0.
- R9: Once results are flowing, consecutive `pcm_valid` pulses are exactly 64 microphone clock periods apart, that is 64*`CLK_DIV` system cycles.
- R10: `pcm_data` and `pcm_src` change only in a cycle where `pcm_valid` is high, and hold their values between pulses.
- R11: During reset `pcm_valid`, `pcm_data` and `pcm_src` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_sel | input | 1 | Sampling-edge choice, captured only during reset (0 = rising, 1 = falling) |
| pdm_data | input | 1 | Raw one-bit data from the microphone |
| mic_clk | output | 1 | Generated microphone bit clock |
| mic_sel | output | 1 | Edge-select level driven to the microphone |
| pcm_data | output | PCM_W (7) | Latest ones count, saturated |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample |
| pcm_src | output | 1 | Counter that produced the current sample (0 or 1) |

## Verification
Every captured bit is counted by both counters in the same cycle. So when one counter closes its window, the other counter is in the middle of its own window and takes that same bit. The closing counter reloads from zero at that instant. A step pattern provokes this case: the input is all ones for bits 0 to 127 and all zeros afterwards. The check is that counter 1's first window reports exactly 64, which shows that bit 127 both finished counter 0's window and was counted in counter 1's window. Separately, the bench drives the inverted bit around the edge that should be ignored and flips `edge_sel` in the middle of a run, so any sampling on the wrong edge shows up as wrong counts.

// File: rtl/pdm_dec_pkg.sv
package pdm_dec_pkg;

  // Identity of the two staggered ones-count windows.
  typedef enum logic {
    WIN_LEAD = 1'b0,
    WIN_LAG  = 1'b1
  } win_id_e;

  localparam longint unsigned MIC_HZ_MIN = 64'd1_000_000;
  localparam longint unsigned MIC_HZ_MAX = 64'd3_300_000;

  // True when the divider is even, at least 4, and lands in the legal band.
  function automatic bit mic_rate_ok(longint unsigned sys_hz, longint unsigned div);
    if (div < 4 || (div % 2) != 0) return 1'b0;
    return (sys_hz / div >= MIC_HZ_MIN) && (sys_hz / div <= MIC_HZ_MAX);
  endfunction

  function automatic bit is_pow2(longint unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/pdm_clk_gen.sv
// Divides the system clock into the microphone clock and flags the first
// system cycle after the selected microphone edge.
module pdm_clk_gen #(
  parameter int unsigned HALF = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_hi,
  output logic mic_clk,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] div_cnt;
  logic          mclk_q;
  logic          flip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      mclk_q  <= 1'b0;
      flip_q  <= 1'b0;
    end else begin
      flip_q <= (div_cnt == TOP);
      if (div_cnt == TOP) begin
        div_cnt <= '0;
        mclk_q  <= ~mclk_q;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // Rising edge wanted when edge_hi is 0: new level is then 1.
  assign tick    = flip_q && (mclk_q == ~edge_hi);
  assign mic_clk = mclk_q;

endmodule

// File: rtl/pdm_bit_sync.sv
// Two-flop synchronizer for the raw data pin, with the capture strobe
// delayed to line up with the synchronized copy.
module pdm_bit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pdm_in,
  output logic bit_stb,
  output logic bit_val
);
  logic meta_q, sync_q;
  logic stb_d1, stb_d2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      stb_d1 <= 1'b0;
      stb_d2 <= 1'b0;
    end else begin
      meta_q <= pdm_in;
      sync_q <= meta_q;
      stb_d1 <= tick;
      stb_d2 <= stb_d1;
    end
  end

  assign bit_stb = stb_d2;
  assign bit_val = sync_q;

endmodule

// File: rtl/pdm_win_acc.sv
// Ones counter over one window position of the shared bit index.
module pdm_win_acc #(
  parameter int unsigned WIN_LEN = 128,
  parameter int unsigned OFFSET  = 0,
  parameter int unsigned OUT_W   = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_stb,
  input  logic                        bit_val,
  input  logic [$clog2(WIN_LEN)-1:0]  bit_idx,
  output logic                        done,
  output logic [OUT_W-1:0]            result
);
  localparam int unsigned POS_W = $clog2(WIN_LEN);
  localparam int unsigned ACC_W = $clog2(WIN_LEN + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(WIN_LEN - 1);
  localparam logic [POS_W-1:0] OFF  = POS_W'(OFFSET % WIN_LEN);
  localparam longint unsigned  OMAX = (64'd1 << OUT_W) - 1;

  logic [POS_W-1:0] pos;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [OUT_W-1:0] sat_val;
  logic             armed;

  assign pos = bit_idx - OFF;
  assign sum = acc + ACC_W'(bit_val);

  always_comb begin
    if (longint'(sum) > longint'(OMAX)) sat_val = OUT_W'(OMAX);
    else                                sat_val = OUT_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      armed  <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (bit_stb) begin
        if (pos == '0) begin
          acc   <= ACC_W'(bit_val);
          armed <= 1'b1;
        end else if (armed) begin
          if (pos == LAST) begin
            done   <= 1'b1;
            result <= sat_val;
            acc    <= '0;
          end else begin
            acc <= sum;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pdm_decimator.sv
module pdm_decimator #(
  parameter int unsigned SYS_HZ  = 100_000_000,
  parameter int unsigned CLK_DIV = 42,
  parameter int unsigned WIN_LEN = 128,
  parameter int unsigned PCM_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_sel,
  input  logic             pdm_data,
  output logic             mic_clk,
  output logic             mic_sel,
  output logic [PCM_W-1:0] pcm_data,
  output logic             pcm_valid,
  output logic             pcm_src
);
  import pdm_dec_pkg::*;

  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned POS_W = $clog2(WIN_LEN);
  localparam int unsigned GAP   = WIN_LEN / 2;
  localparam int unsigned NWIN  = 2;

  if (!mic_rate_ok(longint'(SYS_HZ), longint'(CLK_DIV))) begin : g_bad_rate
    $error("pdm_decimator: divider gives a microphone clock outside 1..3.3 MHz");
  end
  if (!is_pow2(longint'(WIN_LEN)) || WIN_LEN < 4) begin : g_bad_win
    $error("pdm_decimator: window length must be a power of two, at least 4");
  end

  logic sel_q;
  logic tick;
  logic bit_stb;
  logic bit_val;
  logic [POS_W-1:0] bit_idx;
  logic [NWIN-1:0]  done_v;
  logic [NWIN-1:0][PCM_W-1:0] res_v;
  logic [PCM_W-1:0] pick_res;
  win_id_e          pick_id;

  // Edge choice is frozen outside reset.
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= edge_sel;
  end
  assign mic_sel = sel_q;

  pdm_clk_gen #(.HALF(HALF)) u_clk_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_hi (sel_q),
    .mic_clk (mic_clk),
    .tick    (tick)
  );

  pdm_bit_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pdm_in  (pdm_data),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       bit_idx <= '0;
    else if (bit_stb) bit_idx <= bit_idx + 1'b1;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    pdm_win_acc #(
      .WIN_LEN (WIN_LEN),
      .OFFSET  (g * GAP),
      .OUT_W   (PCM_W)
    ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .bit_idx (bit_idx),
      .done    (done_v[g]),
      .result  (res_v[g])
    );
  end

  // Windows are staggered, so at most one closes per bit.
  always_comb begin
    pick_res = res_v[0];
    pick_id  = WIN_LEAD;
    if (done_v[1]) begin
      pick_res = res_v[1];
      pick_id  = WIN_LAG;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcm_valid <= 1'b0;
      pcm_data  <= '0;
      pcm_src   <= 1'b0;
    end else begin
      pcm_valid <= |done_v;
      if (|done_v) begin
        pcm_data <= pick_res;
        pcm_src  <= pick_id;
      end
    end
  end

endmodule

// File: rtl/pdm_dec_chk.sv
module pdm_dec_chk #(
  parameter int unsigned HALF    = 21,
  parameter int unsigned SPACING = 2688,
  parameter int unsigned PCM_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mic_clk,
  input logic             mic_sel,
  input logic [PCM_W-1:0] pcm_data,
  input logic             pcm_valid,
  input logic             pcm_src
);
  int unsigned tog_cnt;
  int unsigned gap_cnt;
  logic        mclk_q;
  logic        seen;
  logic        last_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_cnt  <= 0;
      gap_cnt  <= 0;
      mclk_q   <= 1'b0;
      seen     <= 1'b0;
      last_src <= 1'b0;
    end else begin
      mclk_q <= mic_clk;
      if (mic_clk != mclk_q)           tog_cnt <= 1;
      else if (tog_cnt < 32'hFFFF_0000) tog_cnt <= tog_cnt + 1;
      if (pcm_valid) begin
        gap_cnt  <= 1;
        seen     <= 1'b1;
        last_src <= pcm_src;
      end else if (gap_cnt < 32'hFFFF_0000) begin
        gap_cnt <= gap_cnt + 1;
      end
    end
  end

  a_r1_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mic_clk != mclk_q) |-> (tog_cnt == HALF));

  a_r4_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mic_sel));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);

  a_r8_first_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && !seen) |-> (pcm_src == 1'b0));

  a_r8_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && seen) |-> (pcm_src != last_src));

  a_r9_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && seen) |-> (gap_cnt == SPACING));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> ($stable(pcm_data) && $stable(pcm_src)));

endmodule

bind pdm_decimator pdm_dec_chk #(
  .HALF    (CLK_DIV / 2),
  .SPACING ((WIN_LEN / 2) * CLK_DIV),
  .PCM_W   (PCM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mic_clk   (mic_clk),
  .mic_sel   (mic_sel),
  .pcm_data  (pcm_data),
  .pcm_valid (pcm_valid),
  .pcm_src   (pcm_src)
);

// File: tb/pdm_decimator_bench.sv
module pdm_decimator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 8_000_000;
  localparam int CLK_DIV    = 4;
  localparam int WIN        = 128;
  localparam int NOUT       = 6;
  localparam int WD_LIMIT   = 100_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       edge_sel = 1'b0;
  logic       pdm_data = 1'b0;
  logic       mic_clk, mic_sel, pcm_valid, pcm_src;
  logic [6:0] pcm_data;

  pdm_decimator #(.SYS_HZ(SYS_HZ), .CLK_DIV(CLK_DIV), .WIN_LEN(WIN), .PCM_W(7)) u_pdm_decimator (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .pdm_data(pdm_data),
    .mic_clk(mic_clk), .mic_sel(mic_sel), .pcm_data(pcm_data),
    .pcm_valid(pcm_valid), .pcm_src(pcm_src)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    bit    src;
    int    val;
    string req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cur_pat = 0;
  bit cur_sel = 0;
  int idx = 0;
  bit mc_prev = 0, pend_bad = 0, pend_good = 0;
  int last_rise = -1, r1_period = -1;
  bit have_last = 0;
  int last_v_cyc = 0;
  int last_val = 0;
  int prev_data = 0;

  function automatic bit pat(int p, int k);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return (k % 2) == 0;
      3: return (k % 4) != 0;
      default: return k < WIN;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Data driver: the wanted bit only around the selected edge, its inverse
  // around the other edge (R3).
  always @(negedge clk) begin
    if (!rst_n) begin
      mc_prev = 0; pend_bad = 0; pend_good = 0;
    end else begin
      if (mic_clk != mc_prev) begin
        if (mic_clk == 1'b1) begin
          if (last_rise >= 0 && r1_period < 0) r1_period = cyc - last_rise;
          last_rise = cyc;
        end
        if (mic_clk == ~cur_sel) begin
          idx++;
          pend_bad = 1;
        end else begin
          pend_good = 1;
        end
      end else if (pend_bad) begin
        pdm_data = ~pat(cur_pat, idx - 1);
        pend_bad = 0;
      end else if (pend_good) begin
        pdm_data = pat(cur_pat, idx);
        pend_good = 0;
      end
      mc_prev = mic_clk;
    end
  end

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && pcm_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected sample", pcm_data, -1);
      end else begin
        item_t it;
        it = q.pop_front();
        check(pcm_src == it.src, "R8 source order", pcm_src, it.src);
        check(pcm_data == it.val, it.req, pcm_data, it.val);
        if (have_last) begin
          check(cyc - last_v_cyc == (WIN / 2) * CLK_DIV, "R9 spacing",
                cyc - last_v_cyc, (WIN / 2) * CLK_DIV);
          check(prev_data == last_val, "R10 hold", prev_data, last_val);
        end
        have_last  = 1;
        last_v_cyc = cyc;
        last_val   = it.val;
      end
    end
    prev_data = pcm_data;
  end

  task automatic push_expected(int p);
    for (int w = 0; w < NOUT; w++) begin
      item_t it;
      int start, sum;
      it.src = w % 2;
      start  = (w / 2) * WIN + it.src * (WIN / 2);
      sum = 0;
      for (int k = start; k < start + WIN; k++) sum += pat(p, k);
      it.val = (sum > 127) ? 127 : sum;
      it.req = $sformatf("%s %s pattern %0d", it.src ? "R6" : "R5",
                         (sum > 127) ? "R7" : (cur_sel ? "R3" : "R4"), p);
      q.push_back(it);
    end
  endtask

  task automatic run_phase(int p);
    @(negedge clk);
    rst_n = 0;
    cur_sel = (p % 2) == 1;
    edge_sel = cur_sel;
    cur_pat = p;
    idx = 0;
    pdm_data = pat(p, 0);
    have_last = 0;
    last_rise = -1;
    r1_period = -1;
    repeat (4) @(negedge clk);
    check(mic_clk == 1'b0, "R1 reset level", mic_clk, 0);
    check(pcm_valid == 1'b0 && pcm_src == 1'b0, "R11 reset strobe/src",
          {pcm_valid, pcm_src}, 0);
    check(pcm_data == 0, "R11 reset data", pcm_data, 0);
    check(mic_sel == cur_sel, "R3 select drive", mic_sel, cur_sel);
    push_expected(p);
    rst_n = 1;
    if (p == 2 || p == 3) begin
      repeat (300) @(negedge clk);
      edge_sel = ~edge_sel;  // R4: must be ignored
    end
    while (q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(mic_sel == cur_sel, "R4 select frozen", mic_sel, cur_sel);
    check(r1_period == CLK_DIV, "R1 period", r1_period, CLK_DIV);
  endtask

  initial begin
    for (int p = 0; p < 5; p++) run_phase(p);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule